// File: doc/BRIEF.md
# Balance Command Controller for Six Cell Channels

This block keeps the active balancing command for a group of cell-balancer channels and decides, every clock, which channel gates may be driven. Each channel takes a 2-bit request (off, discharge or charge). A new command word arrives with a one-clock load strobe. The block checks it and either stores it or drops it and pulses a reject flag. The last accepted command stays stored until a better one replaces it or reset clears it.

A mode input picks between independent channels and a shared-transformer arrangement. In the shared arrangement, all channels use one secondary winding, so no more than one of them may run at once. Two conditions suspend every output: a pause request, and an over-voltage fault that has first passed a deglitch filter. Neither condition touches the stored command, so balancing carries on from the same command once the condition goes away. Gate timing and current sensing belong to other blocks.

Top module: `balance_cmd_ctrl`

## Requirements
- R1: While reset is active and after it is released, the stored command is all-off. `dis_en`, `chg_en` and `cmd_reject` are all low.
- R2: Channel i reads bits [2i+1:2i] of `cmd_word`. Code 00 means off, 01 means discharge (drives `dis_en[i]`) and 10 means charge (drives `chg_en[i]`). A command accepted at one clock edge shows on the enables after the next edge.
- R3: A command with code 11 in any field is rejected, and the command stored before it stays in force.
- R4: When `shared_mode` is high, a command that asks for two or more non-off channels is rejected. When `shared_mode` is low, such a command is accepted.
- R5: `cmd_reject` is high for exactly one clock, the one after the edge that sampled each rejected load. It stays low after an accepted load.
- R6: While `shared_mode` is high, no more than one enable bit across `dis_en` and `chg_en` is high. If the stored command has several active channels, all outputs are off.
- R7: `pause_req` high turns every enable off after the next edge. When it goes low, the enables return from the unchanged stored command.
- R8: The fault input turns every enable off once it has been high for 3 consecutive samples, with outputs off 5 clocks after it first goes high. Outputs return from the stored command 5 clocks after the fault has been low for 3 consecutive samples.
- R9: A fault pulse shorter than 3 samples has no effect on the outputs. This applies both to a high glitch while running and to a low glitch while suspended.
- R10: A valid command loaded while outputs are suspended is stored without a reject. It appears on the enables once the suspension ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_word | input | 12 | Command word, 2 bits per channel |
| cmd_load | input | 1 | Load strobe for `cmd_word` |
| shared_mode | input | 1 | High: shared transformer, one channel at a time |
| pause_req | input | 1 | High: suspend all outputs |
| ovp_raw | input | 1 | Raw secondary over-voltage fault |
| dis_en | output | 6 | Per-channel discharge enables |
| chg_en | output | 6 | Per-channel charge enables |
| cmd_reject | output | 1 | One-clock pulse when a load is ignored |

## Verification
Command loading and output suspension can happen in the same cycle. The bench loads a valid command while the filtered fault holds the outputs off, and again in the very cycle that a pause is raised. In both cases it expects no reject pulse, enables that stay off for the whole suspension, and the new command (not the previous one) on the enables in the exact cycle the suspension lifts. A scoreboard stamps each expectation with its target cycle and compares it there.

// File: rtl/bal_cmd_pkg.sv
package bal_cmd_pkg;
   localparam int FIELD_W = 2;

   typedef enum logic [FIELD_W-1:0] {
      CH_OFF = 2'b00,
      CH_DIS = 2'b01,
      CH_CHG = 2'b10,
      CH_RSV = 2'b11
   } ch_req_e;
endpackage

// File: rtl/bal_cmd_decode.sv
module bal_cmd_decode
   import bal_cmd_pkg::*;
#(
   parameter int NUM_CH = 6
) (
   input  logic [NUM_CH*FIELD_W-1:0] cmd,
   output logic [NUM_CH-1:0]         dis_vec,
   output logic [NUM_CH-1:0]         chg_vec,
   output logic                      rsv_any,
   output logic                      multi
);
   logic [NUM_CH-1:0] rsv_vec;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      ch_req_e req;
      assign req        = ch_req_e'(cmd[i*FIELD_W +: FIELD_W]);
      assign dis_vec[i] = (req == CH_DIS);
      assign chg_vec[i] = (req == CH_CHG);
      assign rsv_vec[i] = (req == CH_RSV);
   end

   assign rsv_any = |rsv_vec;
   assign multi   = $countones(dis_vec | chg_vec | rsv_vec) > 1;
endmodule

// File: rtl/bal_fault_filter.sv
module bal_fault_filter #(
   parameter int FILT_LEN = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   output logic flt
);
   if (FILT_LEN < 1) begin : g_bad_len
      $error("FILT_LEN must be at least 1");
   end

   logic [FILT_LEN-1:0] smp;
   logic                flt_q;

   if (FILT_LEN == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) smp <= '0;
         else        smp <= raw;
   end else begin : g_shift
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) smp <= '0;
         else        smp <= {smp[FILT_LEN-2:0], raw};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         flt_q <= 1'b0;
      else if (&smp)      flt_q <= 1'b1;
      else if (~|smp)     flt_q <= 1'b0;
   end

   assign flt = flt_q;

   // R9: the filtered level only moves after a full run of equal samples
   a_r9_full_run: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_q != $past(flt_q)) |-> ($past(smp) == '1 || $past(smp) == '0));
endmodule

// File: rtl/bal_out_gate.sv
module bal_out_gate #(
   parameter int NUM_CH = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] dis_vec,
   input  logic [NUM_CH-1:0] chg_vec,
   input  logic              bad_cmd,
   input  logic              shared_mode,
   input  logic              pause_req,
   input  logic              fault,
   output logic [NUM_CH-1:0] dis_en,
   output logic [NUM_CH-1:0] chg_en
);
   logic kill;
   assign kill = pause_req | fault | bad_cmd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dis_en <= '0;
         chg_en <= '0;
      end else if (kill) begin
         dis_en <= '0;
         chg_en <= '0;
      end else begin
         dis_en <= dis_vec;
         chg_en <= chg_vec;
      end
   end

   // R6: shared transformer never sees two channels
   a_r6_single_channel: assert property (@(posedge clk) disable iff (!rst_n)
      shared_mode |=> $onehot0(dis_en | chg_en));
   // R7: pause blanks outputs
   a_r7_pause_off: assert property (@(posedge clk) disable iff (!rst_n)
      pause_req |=> (dis_en == '0 && chg_en == '0));
   // R8: filtered fault blanks outputs
   a_r8_fault_off: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> (dis_en == '0 && chg_en == '0));
endmodule

// File: rtl/balance_cmd_ctrl.sv
module balance_cmd_ctrl
   import bal_cmd_pkg::*;
#(
   parameter int NUM_CH   = 6,
   parameter int FILT_LEN = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_CH*FIELD_W-1:0] cmd_word,
   input  logic                      cmd_load,
   input  logic                      shared_mode,
   input  logic                      pause_req,
   input  logic                      ovp_raw,
   output logic [NUM_CH-1:0]         dis_en,
   output logic [NUM_CH-1:0]         chg_en,
   output logic                      cmd_reject
);
   localparam int CMD_W = NUM_CH * FIELD_W;

   if (NUM_CH < 1 || NUM_CH > 32) begin : g_bad_ch
      $error("NUM_CH must be within 1..32");
   end

   logic [CMD_W-1:0]  stored;
   logic [NUM_CH-1:0] new_dis, new_chg, st_dis, st_chg;
   logic              new_rsv, new_multi, st_rsv, st_multi;
   logic              new_bad, fault_f;

   bal_cmd_decode #(.NUM_CH(NUM_CH)) i_dec_new (
      .cmd(cmd_word), .dis_vec(new_dis), .chg_vec(new_chg),
      .rsv_any(new_rsv), .multi(new_multi));

   bal_cmd_decode #(.NUM_CH(NUM_CH)) i_dec_st (
      .cmd(stored), .dis_vec(st_dis), .chg_vec(st_chg),
      .rsv_any(st_rsv), .multi(st_multi));

   assign new_bad = new_rsv | (shared_mode & new_multi);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stored     <= '0;
         cmd_reject <= 1'b0;
      end else begin
         cmd_reject <= cmd_load & new_bad;
         if (cmd_load && !new_bad) stored <= cmd_word;
      end
   end

   bal_fault_filter #(.FILT_LEN(FILT_LEN)) i_filt (
      .clk(clk), .rst_n(rst_n), .raw(ovp_raw), .flt(fault_f));

   bal_out_gate #(.NUM_CH(NUM_CH)) i_gate (
      .clk(clk), .rst_n(rst_n), .dis_vec(st_dis), .chg_vec(st_chg),
      .bad_cmd(st_rsv | (shared_mode & st_multi)),
      .shared_mode(shared_mode), .pause_req(pause_req), .fault(fault_f),
      .dis_en(dis_en), .chg_en(chg_en));

   // R5: a reject only follows a load
   a_r5_reject_after_load: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_reject |-> $past(cmd_load));
   // R3: a rejected load leaves the stored command alone
   a_r3_keep_on_reject: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_reject |-> $stable(stored));
   // R3: a reserved code never reaches storage
   a_r3_store_clean: assert property (@(posedge clk) disable iff (!rst_n)
      !st_rsv);
   // R7: suspension without a load keeps the command
   a_r7_pause_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (pause_req && !cmd_load) |=> $stable(stored));
endmodule

// File: tb/test_balance_cmd_ctrl.sv
module test_balance_cmd_ctrl;
   localparam int N = 6;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [2*N-1:0] cmd_word = '0;
   logic           cmd_load = 1'b0;
   logic           shared_mode = 1'b0;
   logic           pause_req = 1'b0;
   logic           ovp_raw = 1'b0;
   logic [N-1:0]   dis_en, chg_en;
   logic           cmd_reject;

   always #5 clk = ~clk;

   balance_cmd_ctrl i_balance_cmd_ctrl (
      .clk(clk), .rst_n(rst_n), .cmd_word(cmd_word), .cmd_load(cmd_load),
      .shared_mode(shared_mode), .pause_req(pause_req), .ovp_raw(ovp_raw),
      .dis_en(dis_en), .chg_en(chg_en), .cmd_reject(cmd_reject));

   typedef struct {
      int           cyc;
      logic [N-1:0] dis;
      logic [N-1:0] chg;
      logic         rej;
      string        tag;
   } exp_t;

   exp_t sb[$];
   int   cnt = 0;
   int   n_chk = 0;
   int   n_fail = 0;
   bit   done = 0;

   // monitor: compares scoreboard items when their cycle comes up
   always @(negedge clk) begin
      cnt++;
      for (int k = sb.size() - 1; k >= 0; k--) begin
         if (sb[k].cyc == cnt) begin
            n_chk++;
            if (dis_en !== sb[k].dis || chg_en !== sb[k].chg || cmd_reject !== sb[k].rej) begin
               n_fail++;
               $display("FAIL %s cyc %0d: got dis=%b chg=%b rej=%b exp dis=%b chg=%b rej=%b",
                        sb[k].tag, cnt, dis_en, chg_en, cmd_reject, sb[k].dis, sb[k].chg, sb[k].rej);
            end
            sb.delete(k);
         end
      end
      if (cnt > 5000 && !done) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog: got cycle %0d exp finish", cnt);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   task automatic expect_at(int d, logic [N-1:0] dis, logic [N-1:0] chg, logic rej, string tag);
      exp_t e;
      e.cyc = cnt + d; e.dis = dis; e.chg = chg; e.rej = rej; e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic load(logic [2*N-1:0] w);
      tick();
      cmd_word = w;
      cmd_load = 1'b1;
   endtask

   initial begin
      // R1: reset state
      tick();
      expect_at(1, '0, '0, 1'b0, "R1 during reset");
      tick(); tick();
      rst_n = 1'b1;
      expect_at(2, '0, '0, 1'b0, "R1 after reset");
      tick(); tick(); tick();

      // R2/R4: ch0 discharge, ch3 charge, independent mode
      load(12'h081);
      expect_at(1, '0, '0, 1'b0, "R5 no reject on accept");
      expect_at(2, 6'b000001, 6'b001000, 1'b0, "R2 R4 independent multi accepted");
      tick(); cmd_load = 1'b0;
      tick(); tick();

      // R3: reserved code in ch3
      load(12'h0C1);
      expect_at(1, 6'b000001, 6'b001000, 1'b1, "R3 R5 reserved rejected");
      expect_at(2, 6'b000001, 6'b001000, 1'b0, "R5 reject lasts one cycle");
      expect_at(3, 6'b000001, 6'b001000, 1'b0, "R3 previous command kept");
      tick(); cmd_load = 1'b0;
      tick(); tick();

      // R6: switch to shared mode with a multi-channel command stored
      tick(); shared_mode = 1'b1;
      expect_at(1, '0, '0, 1'b0, "R6 multi stored blanks in shared mode");
      tick(); tick();

      // R4: shared mode, two discharges
      load(12'h005);
      expect_at(1, '0, '0, 1'b1, "R4 shared multi rejected");
      expect_at(2, '0, '0, 1'b0, "R5 single pulse");
      tick(); cmd_load = 1'b0;
      tick();

      // R4: shared mode, single charge on ch4
      load(12'h200);
      expect_at(2, '0, 6'b010000, 1'b0, "R4 shared single accepted");
      tick(); cmd_load = 1'b0;
      tick(); tick();

      // R7: pause and resume
      tick(); pause_req = 1'b1;
      expect_at(1, '0, '0, 1'b0, "R7 pause blanks");
      expect_at(3, '0, '0, 1'b0, "R7 pause holds");
      tick(); tick(); tick();
      pause_req = 1'b0;
      expect_at(1, '0, 6'b010000, 1'b0, "R7 resume same command");
      tick(); tick();

      // R9: 2-cycle fault glitch while running
      tick(); ovp_raw = 1'b1;
      for (int d = 1; d <= 6; d++) expect_at(d, '0, 6'b010000, 1'b0, "R9 high glitch ignored");
      tick(); tick(); ovp_raw = 1'b0;
      repeat (6) tick();

      // R8: real fault
      ovp_raw = 1'b1;
      expect_at(4, '0, 6'b010000, 1'b0, "R8 fault not yet filtered");
      expect_at(5, '0, '0, 1'b0, "R8 fault blanks");
      repeat (6) tick();

      // R10: load a new command while fault suspends
      cmd_word = 12'h004; cmd_load = 1'b1;
      expect_at(1, '0, '0, 1'b0, "R10 load during fault no reject");
      expect_at(3, '0, '0, 1'b0, "R10 stays off during fault");
      tick(); cmd_load = 1'b0;
      repeat (3) tick();

      // R9: low glitch while suspended
      ovp_raw = 1'b0;
      for (int d = 1; d <= 6; d++) expect_at(d, '0, '0, 1'b0, "R9 low glitch ignored");
      tick(); tick(); ovp_raw = 1'b1;
      repeat (6) tick();

      // R8: fault clears, new stored command resumes
      ovp_raw = 1'b0;
      expect_at(4, '0, '0, 1'b0, "R8 still off before filter");
      expect_at(5, 6'b000010, '0, 1'b0, "R8 R10 resume with new command");
      repeat (7) tick();

      // R10: load in the same cycle as pause rises
      pause_req = 1'b1; cmd_word = 12'h001; cmd_load = 1'b1;
      expect_at(1, '0, '0, 1'b0, "R10 pause+load no reject");
      expect_at(2, '0, '0, 1'b0, "R7 off while paused");
      tick(); cmd_load = 1'b0;
      tick(); tick();
      pause_req = 1'b0;
      expect_at(1, 6'b000001, '0, 1'b0, "R10 new command after pause");
      repeat (4) tick();

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule